// File: doc/BRIEF.md
# Fetch-Line Predecode Issue Throttler

This block sits between the instruction fetch stage and the instruction queue. It takes one fetch line at a time. A line carries sixteen raw bytes, a mask marking the byte positions where instructions begin, and two qualifier flags per position: whether that instruction carries a 16-bit immediate and whether it carries a ModR/M byte. A 2-bit input gives the current processor mode. For every marked start position the block writes a small record into the queue through a write port with several slots. Each slot has its own valid bit. A record holds the start offset and a flag marking an instruction whose length can be changed by a prefix.

The write rate is capped. A line with many instructions is split into groups that go out on successive cycles, lowest offsets first. The next line is not taken until the last group of the current line is written. The block also scans the leading prefix bytes of each instruction. If it finds an operand-size override before a 16-bit immediate, or an address-size override before a ModR/M byte outside 64-bit mode, the whole line goes through a slow path that costs a fixed number of cycles. The downstream queue can push back with a ready signal. While it does, the pending group is held unchanged.

Top module: `pd_issue_throttle`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_ready` is 1 and `wr_valid` is all zeros.
- R2: A line accepted at a clock edge with at most six start bits, and no length-changing prefix, is written in full in the cycle that follows. Slot k carries the k-th lowest start offset. The valid bits are packed from slot 0 upwards. The record of slot k sits at `wr_rec[5k+4:5k]`: bits [3:0] hold the offset and bit 4 is the length-change flag.
- R3: A line with more than six start bits is written in groups of six on consecutive cycles, with the remainder in the last group. Seven starts give six records and then one. Sixteen starts give six, six and four.
- R4: Records come out in strictly ascending offset order, both across the slots of one cycle and from one cycle to the next. No start position is skipped or repeated.
- R5: `line_ready` stays 0 until the cycle in which the last group of the current line is written. In that cycle it is 1, so the next line can be taken at the same edge.
- R6: An instruction whose prefix run holds byte 0x66 and whose 16-bit-immediate flag is set is length-changing. Its record has bit 4 set. The line produces no writes for five cycles and starts writing in the sixth cycle after acceptance. A line of up to six instructions therefore occupies six cycles.
- R7: An instruction whose prefix run holds byte 0x67 and whose ModR/M flag is set is length-changing in modes 0, 1 and 2 (real, 16-bit protected, 32-bit protected). In mode 3 (64-bit) it is not.
- R8: REX bytes 0x40 to 0x4F never cause the slow path. Neither does 0x66 without the immediate flag, nor 0x67 without the ModR/M flag. Such lines are timed as in R2 and R3.
- R9: The prefix run of an instruction starts at its start byte and covers at most four bytes. It stops at the first byte that is not a prefix, at the next start position, or at the end of the line. The prefix bytes are 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2, 0xF3 and 0x40 to 0x4F. Bytes outside the run are not examined.
- R10: While `wr_ready` is 0, `wr_valid` and `wr_rec` hold their values. No record is lost or written twice.
- R11: A line with no start bits is consumed in the cycle after acceptance. It writes nothing, and `line_ready` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | A fetch line is offered |
| line_ready | output | 1 | The offered line is taken at this edge |
| line_bytes | input | 128 | Raw line bytes; byte j at bits [8j+7:8j] |
| line_start | input | 16 | Bit j set: an instruction starts at byte j |
| line_imm16 | input | 16 | Bit j set: the instruction at j carries a 16-bit immediate |
| line_modrm | input | 16 | Bit j set: the instruction at j carries a ModR/M byte |
| cpu_mode | input | 2 | 0 real, 1 16-bit protected, 2 32-bit protected, 3 64-bit |
| wr_valid | output | 6 | Per-slot record valid toward the queue |
| wr_rec | output | 30 | Six 5-bit records: {length-change flag, offset} |
| wr_ready | input | 1 | The queue accepts the current group |

## Verification
The bench aims at the seams of the grouping: exactly seven starts, a full sixteen-start line, and an empty line. An off-by-one in the group counter shows up as a missing or doubled record, or as a line that lingers one cycle too long. Prefix runs are probed at their edges: a chain of segment override followed by operand-size override, an override placed after a non-prefix byte, an override that falls behind the next start, and one that sits just past the four-byte window. A scanner that runs too far, or not far enough, flips the slow path. Mode 3 with an address-size override, and REX before flagged instructions, catch a design that treats every override as length-changing. A stall held over several cycles catches outputs that drift, or groups that advance without a handshake.

// File: rtl/pd_pkg.sv
package pd_pkg;

   typedef enum logic [1:0] {
      MODE_REAL   = 2'd0,
      MODE_PROT16 = 2'd1,
      MODE_PROT32 = 2'd2,
      MODE_LONG64 = 2'd3
   } cpu_mode_e;

   localparam logic [7:0] BYTE_OPSIZE   = 8'h66;
   localparam logic [7:0] BYTE_ADDRSIZE = 8'h67;

   // REX occupies 0x40..0x4F
   function automatic logic is_rex(input logic [7:0] b);
      return b[7:4] == 4'h4;
   endfunction

   // any byte that may lead an instruction as a prefix
   function automatic logic is_prefix(input logic [7:0] b);
      logic hit;
      case (b)
         8'h26, 8'h2E, 8'h36, 8'h3E,
         8'h64, 8'h65, 8'h66, 8'h67,
         8'hF0, 8'hF2, 8'hF3: hit = 1'b1;
         default:             hit = 1'b0;
      endcase
      return hit | is_rex(b);
   endfunction

endpackage

// File: rtl/pd_lcp_scan.sv
module pd_lcp_scan
   import pd_pkg::*;
#(
   parameter int LINE_BYTES = 16,
   parameter int SCAN_MAX   = 4
)(
   input  logic [LINE_BYTES*8-1:0] bytes_i,
   input  logic [LINE_BYTES-1:0]   start_i,
   input  logic [LINE_BYTES-1:0]   imm16_i,
   input  logic [LINE_BYTES-1:0]   modrm_i,
   input  logic [1:0]              mode_i,
   output logic [LINE_BYTES-1:0]   lcp_o
);

   logic addr_ovr_counts;
   assign addr_ovr_counts = (mode_i != MODE_LONG64);

   for (genvar p = 0; p < LINE_BYTES; p++) begin : g_pos
      localparam int LIM = (SCAN_MAX < LINE_BYTES - p) ? SCAN_MAX : LINE_BYTES - p;

      always_comb begin : scan
         logic       run;
         logic       saw_op;
         logic       saw_ad;
         logic [7:0] b;
         run    = 1'b1;
         saw_op = 1'b0;
         saw_ad = 1'b0;
         b      = '0;
         for (int k = 0; k < LIM; k++) begin
            b = bytes_i[(p+k)*8 +: 8];
            if (k > 0 && start_i[p+k])
               run = 1'b0;
            if (run && is_prefix(b)) begin
               if (b == BYTE_OPSIZE)   saw_op = 1'b1;
               if (b == BYTE_ADDRSIZE) saw_ad = 1'b1;
            end else begin
               run = 1'b0;
            end
         end
         lcp_o[p] = start_i[p] &&
                    ((saw_op && imm16_i[p]) ||
                     (saw_ad && modrm_i[p] && addr_ovr_counts));
      end
   end

endmodule

// File: rtl/pd_group_pick.sv
module pd_group_pick #(
   parameter int LINE_BYTES = 16,
   parameter int SLOTS      = 6,
   parameter int OFF_W      = $clog2(LINE_BYTES)
)(
   input  logic [LINE_BYTES-1:0]  rem_i,
   output logic [SLOTS-1:0]       sel_valid_o,
   output logic [SLOTS*OFF_W-1:0] sel_off_o,
   output logic [LINE_BYTES-1:0]  taken_o
);

   localparam int CNT_W = $clog2(SLOTS + 1);

   always_comb begin : pick
      logic [CNT_W-1:0] cnt;
      cnt         = '0;
      sel_valid_o = '0;
      sel_off_o   = '0;
      taken_o     = '0;
      for (int p = 0; p < LINE_BYTES; p++) begin
         if (rem_i[p] && (int'(cnt) < SLOTS)) begin
            sel_valid_o[cnt]               = 1'b1;
            sel_off_o[cnt*OFF_W +: OFF_W]  = OFF_W'(p);
            taken_o[p]                     = 1'b1;
            cnt                            = cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pd_slow_timer.sv
module pd_slow_timer #(
   parameter int SLOW_CYC = 6
)(
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic slow_i,
   output logic wait_o
);

   if (SLOW_CYC > 1) begin : g_timer
      localparam int CNT_W = $clog2(SLOW_CYC);
      localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SLOW_CYC - 1);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (load_i)
            cnt_q <= slow_i ? LOAD_VAL : '0;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end

      assign wait_o = (cnt_q != '0);
   end else begin : g_none
      logic unused;
      assign unused = ^{clk, rst_n, load_i, slow_i};
      assign wait_o = 1'b0;
   end

endmodule

// File: rtl/pd_issue_throttle.sv
module pd_issue_throttle
   import pd_pkg::*;
#(
   parameter int LINE_BYTES = 16,
   parameter int SLOTS      = 6,
   parameter int SLOW_CYC   = 6,
   parameter int SCAN_MAX   = 4,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int REC_W     = OFF_W + 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    line_valid,
   output logic                    line_ready,
   input  logic [LINE_BYTES*8-1:0] line_bytes,
   input  logic [LINE_BYTES-1:0]   line_start,
   input  logic [LINE_BYTES-1:0]   line_imm16,
   input  logic [LINE_BYTES-1:0]   line_modrm,
   input  logic [1:0]              cpu_mode,
   output logic [SLOTS-1:0]        wr_valid,
   output logic [SLOTS*REC_W-1:0]  wr_rec,
   input  logic                    wr_ready
);

   // elaboration-time parameter checks
   if (LINE_BYTES < 2)                  begin : g_bad_line  $error("LINE_BYTES too small"); end
   if (SLOTS < 1 || SLOTS > LINE_BYTES) begin : g_bad_slots $error("SLOTS out of range");   end
   if (SLOW_CYC < 1)                    begin : g_bad_slow  $error("SLOW_CYC must be >= 1"); end
   if (SCAN_MAX < 1)                    begin : g_bad_scan  $error("SCAN_MAX must be >= 1"); end

   logic                   held_q;
   logic [LINE_BYTES-1:0]  rem_q;
   logic [LINE_BYTES-1:0]  lcp_q;

   logic [LINE_BYTES-1:0]  lcp_in;
   logic [SLOTS-1:0]       sel_valid;
   logic [SLOTS*OFF_W-1:0] sel_off;
   logic [LINE_BYTES-1:0]  taken;
   logic [LINE_BYTES-1:0]  rest;
   logic                   penalty;
   logic                   emit;
   logic                   done;
   logic                   accept;

   pd_lcp_scan #(.LINE_BYTES(LINE_BYTES), .SCAN_MAX(SCAN_MAX)) u_scan (
      .bytes_i (line_bytes),
      .start_i (line_start),
      .imm16_i (line_imm16),
      .modrm_i (line_modrm),
      .mode_i  (cpu_mode),
      .lcp_o   (lcp_in)
   );

   pd_group_pick #(.LINE_BYTES(LINE_BYTES), .SLOTS(SLOTS), .OFF_W(OFF_W)) u_pick (
      .rem_i       (rem_q),
      .sel_valid_o (sel_valid),
      .sel_off_o   (sel_off),
      .taken_o     (taken)
   );

   pd_slow_timer #(.SLOW_CYC(SLOW_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .slow_i (|lcp_in),
      .wait_o (penalty)
   );

   assign emit       = held_q && !penalty;
   assign rest       = rem_q & ~taken;
   assign done       = emit && (rest == '0) && (wr_ready || (sel_valid == '0));
   assign line_ready = !held_q || done;
   assign accept     = line_valid && line_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         rem_q  <= '0;
         lcp_q  <= '0;
      end else if (accept) begin
         held_q <= 1'b1;
         rem_q  <= line_start;
         lcp_q  <= lcp_in;
      end else if (done) begin
         held_q <= 1'b0;
         rem_q  <= '0;
      end else if (emit && wr_ready) begin
         rem_q  <= rest;
      end
   end

   assign wr_valid = emit ? sel_valid : '0;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [OFF_W-1:0] off;
      assign off = sel_off[i*OFF_W +: OFF_W];
      assign wr_rec[i*REC_W +: REC_W] = (emit && sel_valid[i]) ? {lcp_q[off], off} : '0;
   end

endmodule

// File: rtl/pd_throttle_chk.sv
module pd_throttle_chk #(
   parameter int LINE_BYTES = 16,
   parameter int SLOTS      = 6,
   parameter int OFF_W      = 4,
   parameter int REC_W      = 5
)(
   input logic                   clk,
   input logic                   rst_n,
   input logic                   line_valid,
   input logic                   line_ready,
   input logic [LINE_BYTES-1:0]  line_start,
   input logic [SLOTS-1:0]       wr_valid,
   input logic [SLOTS*REC_W-1:0] wr_rec,
   input logic                   wr_ready
);

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((|wr_valid) && !wr_ready) |=> ($stable(wr_valid) && $stable(wr_rec))); // R10

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((|wr_valid) && !wr_ready) |-> !line_ready); // R5

   AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && line_ready && (line_start == '0)) |=> (wr_valid == '0)); // R11

   for (genvar i = 0; i + 1 < SLOTS; i++) begin : g_pair
      AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
         wr_valid[i+1] |-> wr_valid[i]); // R2
      AST_OFFSET_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
         wr_valid[i+1] |-> (wr_rec[(i+1)*REC_W +: OFF_W] > wr_rec[i*REC_W +: OFF_W])); // R4
   end

endmodule

bind pd_issue_throttle pd_throttle_chk #(
   .LINE_BYTES(LINE_BYTES), .SLOTS(SLOTS), .OFF_W(OFF_W), .REC_W(REC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
   .line_start(line_start), .wr_valid(wr_valid), .wr_rec(wr_rec), .wr_ready(wr_ready)
);

// File: tb/sim_pd_issue_throttle.sv
`timescale 1ns/1ps
module sim_pd_issue_throttle;

   localparam int LB = 16;
   localparam int NS = 6;
   localparam int RW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            line_valid = 1'b0;
   logic            line_ready;
   logic [LB*8-1:0] line_bytes = {LB{8'h90}};
   logic [LB-1:0]   line_start = '0;
   logic [LB-1:0]   line_imm16 = '0;
   logic [LB-1:0]   line_modrm = '0;
   logic [1:0]      cpu_mode = 2'd2;
   logic [NS-1:0]   wr_valid;
   logic [NS*RW-1:0] wr_rec;
   logic            wr_ready = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #4 clk = ~clk;

   pd_issue_throttle u0 (
      .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
      .line_bytes(line_bytes), .line_start(line_start), .line_imm16(line_imm16),
      .line_modrm(line_modrm), .cpu_mode(cpu_mode), .wr_valid(wr_valid),
      .wr_rec(wr_rec), .wr_ready(wr_ready)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic logic [LB*8-1:0] put(input logic [LB*8-1:0] v, input int j, input logic [7:0] b);
      logic [LB*8-1:0] r;
      r = v;
      r[j*8 +: 8] = b;
      return r;
   endfunction

   // offer a line, wait for acceptance; returns at the negedge of the cycle after acceptance
   task automatic send(input logic [LB*8-1:0] bytes, input logic [LB-1:0] st,
                       input logic [LB-1:0] imm, input logic [LB-1:0] mrm, input logic [1:0] md);
      line_bytes = bytes; line_start = st; line_imm16 = imm; line_modrm = mrm; cpu_mode = md;
      line_valid = 1'b1;
      while (!line_ready) @(negedge clk);
      @(negedge clk);
      line_valid = 1'b0;
   endtask

   // expected behaviour built from the start mask and the expected length-change mask
   task automatic run_line(input string req, input logic [LB*8-1:0] bytes, input logic [LB-1:0] st,
                           input logic [LB-1:0] imm, input logic [LB-1:0] mrm, input logic [1:0] md,
                           input logic [LB-1:0] exp_lcp, input bit slow, input int stall);
      int idx[LB];
      int n = 0;
      int groups;
      for (int p = 0; p < LB; p++) if (st[p]) begin idx[n] = p; n++; end
      groups = (n == 0) ? 1 : (n + NS - 1) / NS;
      wr_ready = (stall > 0) ? 1'b0 : 1'b1;
      send(bytes, st, imm, mrm, md);
      if (slow) begin
         for (int c = 0; c < 5; c++) begin
            chk({req, " idle wr_valid"}, 64'(wr_valid), 64'd0);
            chk({req, " idle line_ready"}, 64'(line_ready), 64'd0);
            @(negedge clk);
         end
      end
      for (int g = 0; g < groups; g++) begin
         logic [NS-1:0]    ev;
         logic [NS*RW-1:0] er;
         logic [NS*RW-1:0] mk;
         ev = '0; er = '0; mk = '0;
         for (int s = 0; s < NS; s++) begin
            int j;
            j = g * NS + s;
            if (j < n) begin
               ev[s] = 1'b1;
               er[s*RW +: RW] = {exp_lcp[idx[j]], 4'(idx[j])};
               mk[s*RW +: RW] = '1;
            end
         end
         if (g == 0) begin
            for (int c = 0; c < stall; c++) begin
               chk({req, " stalled wr_valid"}, 64'(wr_valid), 64'(ev));
               chk({req, " stalled wr_rec"}, 64'(wr_rec & mk), 64'(er));
               chk({req, " stalled line_ready"}, 64'(line_ready), 64'd0);
               @(negedge clk);
            end
            wr_ready = 1'b1;
         end
         chk({req, " wr_valid"}, 64'(wr_valid), 64'(ev));
         chk({req, " wr_rec"}, 64'(wr_rec & mk), 64'(er));
         chk({req, " line_ready"}, 64'(line_ready), 64'(g == groups - 1));
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset line_ready", 64'(line_ready), 64'd1);
      chk("R1 reset wr_valid", 64'(wr_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset wr_valid", 64'(wr_valid), 64'd0);
      chk("R1 after reset line_ready", 64'(line_ready), 64'd1);
   endtask

   task automatic t_group_sizes();
      run_line("R2 four starts", {LB{8'h90}}, 16'h1089, '0, '0, 2'd2, '0, 0, 0);
      run_line("R3 seven starts", {LB{8'h90}}, 16'h1555, '0, '0, 2'd2, '0, 0, 0);
      run_line("R3 R4 sixteen starts", {LB{8'h90}}, 16'hFFFF, '0, '0, 2'd2, '0, 0, 0);
      run_line("R2 six starts", {LB{8'h90}}, 16'h8421 | 16'h0300, '0, '0, 2'd2, '0, 0, 0);
   endtask

   task automatic t_opsize();
      logic [LB*8-1:0] b;
      b = put({LB{8'h90}}, 0, 8'h66);
      run_line("R6 opsize imm16", b, 16'h0021, 16'h0001, '0, 2'd2, 16'h0001, 1, 0);
      run_line("R8 opsize no imm16", b, 16'h0021, 16'h0000, '0, 2'd2, '0, 0, 0);
      run_line("R6 R3 slow sixteen", b, 16'hFFFF, 16'h0001, '0, 2'd2, 16'h0001, 1, 0);
   endtask

   task automatic t_addrsize();
      logic [LB*8-1:0] b;
      b = put({LB{8'h90}}, 3, 8'h67);
      run_line("R7 addr mode0", b, 16'h0108, '0, 16'h0008, 2'd0, 16'h0008, 1, 0);
      run_line("R7 addr mode1", b, 16'h0108, '0, 16'h0008, 2'd1, 16'h0008, 1, 0);
      run_line("R7 addr mode2", b, 16'h0108, '0, 16'h0008, 2'd2, 16'h0008, 1, 0);
      run_line("R7 addr mode3", b, 16'h0108, '0, 16'h0008, 2'd3, '0, 0, 0);
      run_line("R8 addr no modrm", b, 16'h0108, '0, 16'h0000, 2'd1, '0, 0, 0);
   endtask

   task automatic t_rex();
      logic [LB*8-1:0] b;
      b = put({LB{8'h90}}, 0, 8'h48);
      b = put(b, 6, 8'h4F);
      run_line("R8 rex", b, 16'h0041, 16'h0041, 16'h0041, 2'd2, '0, 0, 0);
   endtask

   task automatic t_scan();
      logic [LB*8-1:0] b;
      b = put(put({LB{8'h90}}, 0, 8'h2E), 1, 8'h66);
      run_line("R9 chained prefixes", b, 16'h0011, 16'h0001, '0, 2'd2, 16'h0001, 1, 0);
      b = put({LB{8'h90}}, 1, 8'h66);
      run_line("R9 after opcode", b, 16'h0011, 16'h0001, '0, 2'd2, '0, 0, 0);
      b = put(put({LB{8'h90}}, 0, 8'h2E), 1, 8'h66);
      run_line("R9 stops at next start", b, 16'h0003, 16'h0001, '0, 2'd2, '0, 0, 0);
      b = put(put(put(put(put({LB{8'h90}}, 0, 8'h2E), 1, 8'h3E), 2, 8'h26), 3, 8'hF0), 4, 8'h66);
      run_line("R9 window limit", b, 16'h0101, 16'h0001, '0, 2'd2, '0, 0, 0);
      b = put({LB{8'h90}}, 15, 8'h66);
      run_line("R9 line end", b, 16'h8001, 16'h8000, '0, 2'd2, 16'h8000, 1, 0);
   endtask

   task automatic t_stall();
      run_line("R10 stall seven", {LB{8'h90}}, 16'h1555, '0, '0, 2'd2, '0, 0, 3);
   endtask

   task automatic t_empty();
      run_line("R11 empty line", {LB{8'h90}}, 16'h0000, '0, '0, 2'd2, '0, 0, 0);
      run_line("R11 line after empty", {LB{8'h90}}, 16'h0006, '0, '0, 2'd2, '0, 0, 0);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_group_sizes();
      t_opsize();
      t_addrsize();
      t_rex();
      t_scan();
      t_stall();
      t_empty();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule